// File: doc/BRIEF.md
# Shadow-Backed Static RAM Controller

This block models a byte-wide static RAM whose contents can be saved into, and brought back from, a second non-volatile shadow array. The host uses it like an ordinary asynchronous SRAM. Active-low chip-enable, output-enable and write-enable pins decode read and write cycles into the working array. A shared active-low store strobe line does two jobs. Any party pulls it low to request a save. The block holds it low while a save or restore is under way, so the line also reports that the array is busy.

A save copies the whole working array into the shadow array. It can be started in three ways: a falling edge on the strobe line, a one-cycle software request pulse, or a rising edge on a power-fail indication. A software request always runs. The strobe and power-fail triggers run only if the working array has been written since the last save or restore. A restore copies the shadow array back into the working array. It runs by itself every time reset is released, which stands in for power-up. The shadow array is never reset. While a copy runs, the bus is locked out: reads and writes have no effect.

Each copy is a sequence that moves one word per clock. A save keeps the array busy for a window of `STORE_CYCLES` clocks, and that window is stretched to at least the array depth. A restore takes exactly one clock per word. The full-size part uses `ADDR_W = 13`, which gives 8,192 bytes. The default is a smaller depth.

Top module: `nvsram_ctrl`

## Requirements
- R1: When ce_n=0, oe_n=0, we_n=1 and hsb_in=1 while no copy runs, dq_oe is 1 and dq_out shows the word at addr in the same cycle. In every other case dq_oe is 0 and dq_out is 0.
- R2: At each rising clock edge where ce_n=0, we_n=0 and hsb_in=1 while no copy runs, dq_in is written at addr. During such a write cycle dq_oe stays 0, even when oe_n=0.
- R3: While hsb_pull_low is 1, reads give dq_oe=0 and write cycles leave the array unchanged.
- R4: A sw_store_req sampled high at an edge while idle starts a save whether or not any write has happened. hsb_pull_low is then 1 for exactly max(STORE_CYCLES, 2**ADDR_W) cycles, starting after that edge.
- R5: A falling edge of hsb_in (1 at one edge, 0 at the next) seen while idle starts a save only if a write has happened since the last save or restore. Otherwise it is ignored.
- R6: A rising edge of pwr_fail seen while idle starts a save under the same written-since condition as R5.
- R7: While rst=1, hsb_pull_low is 1 and dq_oe is 0. After rst falls, a restore keeps hsb_pull_low at 1 for exactly 2**ADDR_W cycles and loads every word of the last save into the working array. The shadow array keeps its contents across reset.
- R8: The written-since flag clears when any save or restore ends. A strobe or power-fail trigger that follows with no write in between starts nothing.
- R9: A save request of any kind that arrives while a copy runs is ignored and does not lengthen the busy window.
- R10: A write accepted at the same edge at which a save request is sampled lands in the array and is included in that save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up); a restore follows its release |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data from the shared data bus |
| dq_out | output | DATA_W | Read data onto the shared data bus |
| dq_oe | output | 1 | Data bus drive enable |
| hsb_in | input | 1 | Sensed level of the shared store strobe line |
| hsb_pull_low | output | 1 | Open-drain pull-down of the strobe line; 1 while a copy runs |
| sw_store_req | input | 1 | One-cycle software save request |
| pwr_fail | input | 1 | Supply-loss indication; a rising edge requests a save |

## Verification
Two functions can fall in the same cycle: a bus write and a save request. The bench provokes this by driving a write and a software request in the same cycle. It then overwrites the array, applies reset and reads back the restored contents, which must hold the coincident write's data. A second overlap is forced during a running save. A write attempt, a read attempt and a fresh request are applied mid-copy. Each is judged by the busy window length, by dq_oe, and by a later read of the address that was targeted.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_STORE  = 2'd1,
        XF_RECALL = 2'd2
    } xfer_state_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } bus_op_t;

    typedef struct packed {
        logic hw;
        logic sw;
        logic pwr;
    } store_src_t;

    function automatic bus_op_t decode_bus(
        input logic ce_n,
        input logic oe_n,
        input logic we_n,
        input logic strobe_hi,
        input logic idle
    );
        bus_op_t op;
        op.rd = idle && !ce_n && !oe_n && we_n && strobe_hi;
        op.wr = idle && !ce_n && !we_n && strobe_hi;
        return op;
    endfunction

    function automatic int unsigned stretch_len(input int unsigned want, input int unsigned floor_len);
        return (want < floor_len) ? floor_len : want;
    endfunction

endpackage

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              copy_store,
    input  logic              copy_recall,
    input  logic [ADDR_W-1:0] copy_idx
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] work   [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];

    // working array: bus writes or restore traffic (never both at once)
    always_ff @(posedge clk) begin
        if (wr_en) begin
            work[wr_addr] <= wr_data;
        end else if (copy_recall) begin
            work[copy_idx] <= shadow[copy_idx];
        end
    end

    // shadow array: no reset, survives power-up
    always_ff @(posedge clk) begin
        if (copy_store) begin
            shadow[copy_idx] <= work[copy_idx];
        end
    end

    assign rd_data = work[rd_addr];

endmodule

// File: rtl/nvs_store_trigger.sv
module nvs_store_trigger
    import nvs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic wr_strobe,
    input  logic hsb_in,
    input  logic sw_store_req,
    input  logic pwr_fail,
    input  logic xfer_done,
    output logic start_store,
    output logic dirty
);
    logic       hsb_q;
    logic       pf_q;
    store_src_t src;

    always_ff @(posedge clk) begin
        if (rst) begin
            hsb_q <= 1'b1;
            pf_q  <= 1'b0;
        end else begin
            hsb_q <= hsb_in;
            pf_q  <= pwr_fail;
        end
    end

    always_comb begin
        src.hw  = hsb_q && !hsb_in;
        src.pwr = !pf_q && pwr_fail;
        src.sw  = sw_store_req;
    end

    assign start_store = !rst && idle && (src.sw || (dirty && (src.hw || src.pwr)));

    always_ff @(posedge clk) begin
        if (rst || xfer_done) begin
            dirty <= 1'b0;
        end else if (wr_strobe) begin
            dirty <= 1'b1;
        end
    end

endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq
    import nvs_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int STORE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_store,
    output logic              busy,
    output logic              xfer_done,
    output logic              copy_store,
    output logic              copy_recall,
    output logic [ADDR_W-1:0] copy_idx
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int STORE_LEN = int'(stretch_len(STORE_CYCLES, DEPTH));
    localparam int CW        = $clog2(STORE_LEN + 1);

    xfer_state_t    state;
    logic [CW-1:0]  cnt;
    logic           last;
    logic           in_window;

    always_comb begin
        unique case (state)
            XF_STORE:  last = (cnt == CW'(STORE_LEN - 1));
            XF_RECALL: last = (cnt == CW'(DEPTH - 1));
            default:   last = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= XF_RECALL;
            cnt   <= '0;
        end else begin
            unique case (state)
                XF_IDLE: begin
                    cnt <= '0;
                    if (start_store) state <= XF_STORE;
                end
                XF_STORE, XF_RECALL: begin
                    if (last) begin
                        state <= XF_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

    assign in_window   = (cnt < CW'(DEPTH));
    assign busy        = (state != XF_IDLE);
    assign xfer_done   = !rst && last;
    assign copy_store  = !rst && (state == XF_STORE) && in_window;
    assign copy_recall = !rst && (state == XF_RECALL) && in_window;
    assign copy_idx    = cnt[ADDR_W-1:0];

endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 8,
    parameter int STORE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              hsb_in,
    output logic              hsb_pull_low,
    input  logic              sw_store_req,
    input  logic              pwr_fail
);
    bus_op_t           bus_op;
    logic              busy;
    logic              xfer_done;
    logic              start_store;
    logic              dirty_q;
    logic              copy_store;
    logic              copy_recall;
    logic [ADDR_W-1:0] copy_idx;
    logic [DATA_W-1:0] rd_word;

    assign bus_op = decode_bus(ce_n, oe_n, we_n, hsb_in, !busy && !rst);

    nvs_store_trigger u_trig (
        .clk          (clk),
        .rst          (rst),
        .idle         (!busy),
        .wr_strobe    (bus_op.wr),
        .hsb_in       (hsb_in),
        .sw_store_req (sw_store_req),
        .pwr_fail     (pwr_fail),
        .xfer_done    (xfer_done),
        .start_store  (start_store),
        .dirty        (dirty_q)
    );

    nvs_xfer_seq #(
        .ADDR_W       (ADDR_W),
        .STORE_CYCLES (STORE_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_store (start_store),
        .busy        (busy),
        .xfer_done   (xfer_done),
        .copy_store  (copy_store),
        .copy_recall (copy_recall),
        .copy_idx    (copy_idx)
    );

    nvs_arrays #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk         (clk),
        .wr_en       (bus_op.wr),
        .wr_addr     (addr),
        .wr_data     (dq_in),
        .rd_addr     (addr),
        .rd_data     (rd_word),
        .copy_store  (copy_store),
        .copy_recall (copy_recall),
        .copy_idx    (copy_idx)
    );

    assign dq_oe        = bus_op.rd;
    assign dq_out       = bus_op.rd ? rd_word : '0;
    assign hsb_pull_low = busy;

endmodule

// File: rtl/nvs_ctrl_checker.sv
module nvs_ctrl_checker (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic hsb_in,
    input logic dq_oe,
    input logic hsb_pull_low,
    input logic sw_store_req,
    input logic dirty,
    input logic xfer_done,
    input logic copy_store,
    input logic copy_recall
);
    assert_read_decode_R1: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!ce_n && !oe_n && we_n && hsb_in));

    assert_busy_blocks_read_R3: assert property (@(posedge clk) disable iff (rst)
        hsb_pull_low |-> !dq_oe);

    assert_idle_no_copy_R4: assert property (@(posedge clk) disable iff (rst)
        !hsb_pull_low |-> !(copy_store || copy_recall));

    assert_gated_start_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(hsb_pull_low) && !$past(sw_store_req)) |-> $past(dirty));

    assert_end_clears_dirty_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(hsb_pull_low) |-> !dirty);

    assert_hold_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (hsb_pull_low && !xfer_done) |=> hsb_pull_low);

endmodule

bind nvsram_ctrl nvs_ctrl_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .hsb_in       (hsb_in),
    .dq_oe        (dq_oe),
    .hsb_pull_low (hsb_pull_low),
    .sw_store_req (sw_store_req),
    .dirty        (dirty_q),
    .xfer_done    (xfer_done),
    .copy_store   (copy_store),
    .copy_recall  (copy_recall)
);

// File: tb/nvsram_ctrl_test.sv
`timescale 1ns/100ps
module nvsram_ctrl_test;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int SC    = 24;
    localparam int DEPTH = 1 << AW;
    localparam int SLEN  = (SC < DEPTH) ? DEPTH : SC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          hsb_pull_low;
    logic          tb_hsb_low = 1'b0;
    logic          sw_store_req = 1'b0;
    logic          pwr_fail = 1'b0;
    wire           hsb_line = !(tb_hsb_low || hsb_pull_low);

    int vectors = 0;
    int miscomp = 0;

    always #2.5 clk = ~clk;

    nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYCLES(SC)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .hsb_in(hsb_line), .hsb_pull_low(hsb_pull_low),
        .sw_store_req(sw_store_req), .pwr_fail(pwr_fail)
    );

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'((a * 37 + 5) & 255);
    endfunction
    function automatic logic [DW-1:0] pat2(input int a);
        return DW'((a * 11) ^ 8'hA5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        addr = AW'(a); dq_in = d;
        #0.5;
        chk("R2 dq_oe off during write", {31'd0, dq_oe}, 32'd0);
        step();
        bus_idle();
    endtask

    task automatic rd(input string tag, input int a, input logic [DW-1:0] e);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
        #0.5;
        chk(tag, {31'd0, dq_oe}, 32'd1);
        chk(tag, {24'd0, dq_out}, {24'd0, e});
        step();
        bus_idle();
    endtask

    // trigger already driven; take the sampling edge, release, count busy cycles
    task automatic measure(output int n);
        step();
        sw_store_req = 1'b0; tb_hsb_low = 1'b0; bus_idle();
        n = 0;
        while (hsb_pull_low && n < 200) begin
            n++;
            step();
        end
    endtask

    task automatic expect_quiet(input string tag);
        int seen;
        step();
        sw_store_req = 1'b0; tb_hsb_low = 1'b0;
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            if (hsb_pull_low) seen++;
            step();
        end
        chk(tag, 32'(seen), 32'd0);
    endtask

    task automatic do_reset_recall(input string tag);
        int n;
        rst = 1'b1;
        step(); step();
        chk({tag, " busy in reset"}, {31'd0, hsb_pull_low}, 32'd1);
        ce_n = 1'b0; oe_n = 1'b0;
        #0.5;
        chk({tag, " no read in reset"}, {31'd0, dq_oe}, 32'd0);
        bus_idle();
        step();
        rst = 1'b0;
        #0.5;
        n = 0;
        while (hsb_pull_low && n < 200) begin
            n++;
            step();
        end
        chk({tag, " recall length"}, 32'(n), 32'(DEPTH));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        miscomp++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        logic [DW-1:0] coinc;
        coinc = 8'h3C;

        // R7: reset state and power-up restore length
        do_reset_recall("R7");

        // R2 / R1: exhaustive write then read sweep
        for (int a = 0; a < DEPTH; a++) wr(a, pat1(a));
        for (int a = 0; a < DEPTH; a++) rd("R1 read sweep", a, pat1(a));
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #0.5;
        chk("R1 no drive when deselected", {31'd0, dq_oe}, 32'd0);
        chk("R1 dq_out zero when off", {24'd0, dq_out}, 32'd0);
        bus_idle();

        // R4 + R3 + R9: software store, with bus and request attempts mid-copy
        sw_store_req = 1'b1;
        step();
        sw_store_req = 1'b0;
        n = 0;
        while (hsb_pull_low && n < 200) begin
            n++;
            bus_idle();
            sw_store_req = 1'b0;
            if (n == 3) begin
                ce_n = 1'b0; we_n = 1'b0; addr = AW'(3); dq_in = 8'h00;
            end
            if (n == 5) begin
                ce_n = 1'b0; oe_n = 1'b0; addr = AW'(5);
                #0.5;
                chk("R3 no read while busy", {31'd0, dq_oe}, 32'd0);
            end
            if (n == 7) sw_store_req = 1'b1;
            step();
        end
        bus_idle(); sw_store_req = 1'b0;
        chk("R4 R9 store window length", 32'(n), 32'(SLEN));
        rd("R3 write ignored while busy", 3, pat1(3));

        // R5 / R8: strobe and power-fail triggers with clean array are ignored
        tb_hsb_low = 1'b1;
        expect_quiet("R5 R8 strobe ignored when clean");
        pwr_fail = 1'b1;
        expect_quiet("R6 R8 power-fail ignored when clean");
        pwr_fail = 1'b0;
        step();

        // R5: strobe after a write runs a store
        wr(0, pat2(0));
        tb_hsb_low = 1'b1;
        measure(n);
        chk("R5 strobe store length", 32'(n), 32'(SLEN));
        pwr_fail = 1'b1;
        expect_quiet("R8 power-fail after store ignored");
        pwr_fail = 1'b0;
        step();

        // R6: power-fail after a write runs a store
        wr(1, pat2(1));
        pwr_fail = 1'b1;
        measure(n);
        chk("R6 power-fail store length", 32'(n), 32'(SLEN));
        pwr_fail = 1'b0;
        step();

        // R10: write and software request in the same cycle
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(2); dq_in = coinc;
        sw_store_req = 1'b1;
        measure(n);
        chk("R10 coincident store length", 32'(n), 32'(SLEN));

        // scribble over the working array, then power-cycle
        for (int a = 0; a < DEPTH; a++) wr(a, ~pat1(a));
        do_reset_recall("R7 second");
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] e;
            e = pat1(a);
            if (a == 0) e = pat2(0);
            if (a == 1) e = pat2(1);
            if (a == 2) e = coinc;
            rd((a == 2) ? "R10 coincident write saved" : "R7 restored contents", a, e);
        end

        // R4: software store runs even with a clean array after restore
        sw_store_req = 1'b1;
        measure(n);
        chk("R4 clean software store length", 32'(n), 32'(SLEN));
        rd("R4 data intact after store", 7, pat1(7));

        finish_run();
    end
endmodule